// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a processor's bus interface and its instruction decoder. It holds instruction bytes taken from the memory bus in first-in-first-out order, so the decoder sees the same byte sequence it would get by reading memory one address after another. When the queue holds nothing, the decoder stalls. Each cycle the decoder may take one byte from the head. The block also reports how many bytes are ready.

Prefetch bus cycles have the lowest bus priority. A request goes out only when no execution-unit memory access is pending, when no earlier prefetch is still outstanding, and when enough byte slots are free. On a control transfer, a flush empties the queue and loads the branch target into the fetch address. A prefetch that is still in flight at that moment has its returned data thrown away. The bus width is a parameter. With a 16-bit bus, one fetch brings two bytes, or only the high byte when the fetch address is odd. With an 8-bit bus, each fetch brings one byte, and the byte-pair storage words are filled half at a time through separate low and high write strobes.

Top module: `pfq_ctrl`

## Requirements
- R1: Bytes leave the queue in the order of ascending fetch addresses from the last flush (or reset) target. The decoder's byte at each pop equals the memory byte at the next sequential address.
- R2: While the queue is empty, `dec_valid_o` is low, and a pop request is ignored, so the count stays 0.
- R3: `pf_req_o` is never high in a cycle where `eu_req_i` is high.
- R4: `pf_req_o` is high only if no prefetch is outstanding and the number of free slots is at least `BUS_BYTES`. The queue therefore stops requesting when full and with one free slot on the 16-bit bus, and resumes at two free slots.
- R5: In the cycle after `flush_i`, `dec_count_o` is 0 and `pf_addr_o` equals the flush target.
- R6: Data returned for a prefetch granted before a flush is never written. This also holds when the return and the flush fall in the same cycle.
- R7: On the 16-bit bus, a fetch from an odd address puts only the high data byte (`rd_data_i[15:8]`) into the queue, and the next fetch uses the following even address. A 16-bit return holds the even-address byte in bits 7:0 and the odd-address byte in bits 15:8.
- R8: `dec_count_o` equals the number of stored bytes, never exceeds `DEPTH`, and changes by the bytes written minus the byte popped.
- R9: After reset the queue is empty, `pf_addr_o` equals `RESET_ADDR`, and a prefetch is requested at once if no data access is pending.
- R10: With `BUS_BYTES`=1 (default depth 4), each fetch writes one byte through a single low or high strobe. The queue fills to exactly 4 bytes and delivers them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Control transfer: discard queue, restart at target |
| flush_addr_i | input | ADDR_W | Branch target address |
| eu_req_i | input | 1 | Execution-unit memory access pending |
| pf_req_o | output | 1 | Prefetch bus cycle request |
| pf_addr_o | output | ADDR_W | Prefetch address |
| pf_grant_i | input | 1 | Bus accepts the prefetch request this cycle |
| rd_valid_i | input | 1 | Prefetch read data returned |
| rd_data_i | input | 8*BUS_BYTES | Returned data |
| dec_rd_i | input | 1 | Decoder takes the head byte |
| dec_byte_o | output | 8 | Head byte |
| dec_valid_o | output | 1 | Queue not empty |
| dec_count_o | output | clog2(DEPTH+1) | Number of bytes held |

## Verification
A flush can land in the same cycle that a granted prefetch returns its data. The returned bytes must then be dropped, and the fetch state must still go back to idle. The bench provokes this by watching the bus model's return strobe away from the clock edge and raising the flush in that same cycle. It judges the result by a zero count on the next cycle and by the first byte later popped, which must come from the new target. A second collision is a pop and a write in the same cycle, which streams with steady popping exercise; it is judged by the count and the byte order.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_DROP = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int BUS_BYTES = 2,
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int CNT_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              eu_req_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pf_grant_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pf_req_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic [1:0]        wr_n_o,
  output logic [7:0]        wr_b0_o,
  output logic [7:0]        wr_b1_o
);
  import pfq_pkg::*;

  localparam logic [CNT_W-1:0] NEED = CNT_W'(BUS_BYTES);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  fetch_state_e     state_q, state_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic             odd_q, odd_d;
  logic             fire, accept, fa_odd;
  logic [ADDR_W-1:0] step;

  generate
    if (BUS_BYTES == 2) begin : g_word
      assign fa_odd  = fa_q[0];
      assign step    = fa_q[0] ? ADDR_W'(1) : ADDR_W'(2);
      assign wr_b0_o = odd_q ? rd_data_i[15:8] : rd_data_i[7:0];
      assign wr_b1_o = rd_data_i[15:8];
      assign wr_n_o  = accept ? (odd_q ? 2'd1 : 2'd2) : 2'd0;
    end else begin : g_byte
      assign fa_odd  = 1'b0;
      assign step    = ADDR_W'(1);
      assign wr_b0_o = rd_data_i[7:0];
      assign wr_b1_o = 8'h00;
      assign wr_n_o  = accept ? 2'd1 : 2'd0;
    end
  endgenerate

  assign pf_req_o  = (state_q == FS_IDLE) && !eu_req_i && ((CAP - count_i) >= NEED);
  assign pf_addr_o = fa_q;
  assign fire      = pf_req_o && pf_grant_i;
  assign accept    = (state_q == FS_WAIT) && rd_valid_i && !flush_i;

  always_comb begin
    state_d = state_q;
    fa_d    = fa_q;
    odd_d   = odd_q;
    if (fire) begin
      odd_d = fa_odd;
      fa_d  = fa_q + step;
    end
    if (flush_i) fa_d = flush_addr_i;
    unique case (state_q)
      FS_IDLE: if (fire) state_d = flush_i ? FS_DROP : FS_WAIT;
      FS_WAIT: begin
        if (rd_valid_i)   state_d = FS_IDLE;
        else if (flush_i) state_d = FS_DROP;
      end
      FS_DROP: if (rd_valid_i) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      fa_q    <= RESET_ADDR;
      odd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fa_q    <= fa_d;
      odd_q   <= odd_d;
    end
  end

  // R6: returns belonging to a flushed fetch never reach storage
  a_r6_drop_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_DROP) |-> (wr_n_o == 2'd0));
  // R4: a request implies no outstanding fetch and room for a full beat
  a_r4_room: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_o |-> (count_i <= CAP - NEED));
endmodule

// File: rtl/pfq_occ.sv
module pfq_occ #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [1:0]       wr_n_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p, input logic [1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign pop_ok = pop_i && (count_q != '0) && !flush_i;

  always_comb begin
    if (flush_i) begin
      count_d = '0;
      head_d  = '0;
      tail_d  = '0;
    end else begin
      count_d = count_q + CNT_W'(wr_n_i) - CNT_W'(pop_ok);
      head_d  = pop_ok ? wrap_add(head_q, 2'd1) : head_q;
      tail_d  = wrap_add(tail_q, wr_n_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      count_q <= count_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
    end
  end

  assign count_o = count_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;

  // R8: occupancy bounded by the depth
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R2: an empty queue stays empty without a write, whatever the decoder does
  a_r2_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && wr_n_i == 2'd0) |=> (count_q == '0));
endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 6,
  parameter int PTR_W = 3,
  parameter int MAX_WR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] tail_i,
  input  logic [1:0]       wr_n_i,
  input  logic [7:0]       b0_i,
  input  logic [7:0]       b1_i,
  input  logic [PTR_W-1:0] head_i,
  output logic [7:0]       rd_byte_o
);
  localparam int WORDS = DEPTH / 2;

  logic [PTR_W-1:0] tail1;
  logic [WORDS-1:0] we_lo, we_hi;
  logic [15:0]      wq [WORDS];
  logic [PTR_W-1:0] hw;

  assign tail1 = (int'(tail_i) + 1 >= DEPTH) ? '0 : tail_i + PTR_W'(1);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [PTR_W-1:0] LO = PTR_W'(2 * w);
    localparam logic [PTR_W-1:0] HI = PTR_W'(2 * w + 1);
    logic [7:0] lo_q, hi_q;
    assign we_lo[w] = ((wr_n_i != 2'd0) && (tail_i == LO)) || ((wr_n_i == 2'd2) && (tail1 == LO));
    assign we_hi[w] = ((wr_n_i != 2'd0) && (tail_i == HI)) || ((wr_n_i == 2'd2) && (tail1 == HI));
    always_ff @(posedge clk) begin
      if (we_lo[w]) lo_q <= (tail_i == LO) ? b0_i : b1_i;
      if (we_hi[w]) hi_q <= (tail_i == HI) ? b0_i : b1_i;
    end
    assign wq[w] = {hi_q, lo_q};
  end

  assign hw        = head_i >> 1;
  assign rd_byte_o = head_i[0] ? wq[hw][15:8] : wq[hw][7:0];

  // R10: never more byte strobes in a cycle than the bus width delivers
  a_r10_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({we_hi, we_lo}) <= MAX_WR);
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl #(
  parameter int BUS_BYTES = 2,
  parameter int DEPTH = (BUS_BYTES == 2) ? 6 : 4,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'('hFFFF0),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int DATA_W = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              eu_req_i,
  output logic              pf_req_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_grant_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              dec_rd_i,
  output logic [7:0]        dec_byte_o,
  output logic              dec_valid_o,
  output logic [CNT_W-1:0]  dec_count_o
);
  logic [1:0]       wr_n;
  logic [7:0]       wr_b0, wr_b1;
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] head, tail;

  pfq_fetch #(
    .BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .RESET_ADDR(RESET_ADDR), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .eu_req_i(eu_req_i), .count_i(count), .pf_grant_i(pf_grant_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .pf_req_o(pf_req_o),
    .pf_addr_o(pf_addr_o), .wr_n_o(wr_n), .wr_b0_o(wr_b0), .wr_b1_o(wr_b1)
  );

  pfq_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_n_i(wr_n),
    .pop_i(dec_rd_i), .count_o(count), .head_o(head), .tail_o(tail)
  );

  pfq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .MAX_WR(BUS_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .tail_i(tail), .wr_n_i(wr_n), .b0_i(wr_b0),
    .b1_i(wr_b1), .head_i(head), .rd_byte_o(dec_byte_o)
  );

  assign dec_count_o = count;
  assign dec_valid_o = (count != '0);

  // R3: data accesses always win the bus
  a_r3_eu_first: assert property (@(posedge clk) disable iff (!rst_n)
    eu_req_i |-> !pf_req_o);
  // R5: a flush empties the queue and retargets fetching
  a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (dec_count_o == '0) && (pf_addr_o == $past(flush_addr_i)));
endmodule

// File: tb/pfq_ctrl_tb.sv
module pfq_mem_model #(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W = 20,
  parameter int LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   gnt_en,
  output logic                   gnt,
  output logic                   rd_valid,
  output logic [8*BUS_BYTES-1:0] rd_data
);
  logic              busy;
  logic [3:0]        cnt;
  logic [ADDR_W-1:0] a;

  function automatic logic [7:0] mb(input logic [ADDR_W-1:0] x);
    return x[7:0] + 8'(x[15:8] * 3) + 8'h11;
  endfunction

  assign gnt = req && gnt_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; a <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (gnt) begin
        busy <= 1'b1; cnt <= 4'(LAT); a <= addr;
      end else if (busy) begin
        cnt <= cnt - 4'd1;
        if (cnt == 4'd1) begin
          busy <= 1'b0;
          rd_valid <= 1'b1;
          if (BUS_BYTES == 2) rd_data <= (8*BUS_BYTES)'({mb(a | ADDR_W'(1)), mb(a & ~ADDR_W'(1))});
          else rd_data <= (8*BUS_BYTES)'(mb(a));
        end
      end
    end
  end
endmodule

module pfq_ctrl_tb;
  localparam int AW = 20;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic flush, eu_req, gnt_en, dec_rd;
  logic [AW-1:0] flush_addr;
  logic pf_req, gnt, rd_valid, dec_valid;
  logic [AW-1:0] pf_addr;
  logic [15:0] rd_data;
  logic [7:0] dec_byte;
  logic [2:0] dec_count;

  logic flush8, dec_rd8;
  logic [AW-1:0] flush_addr8;
  logic pf_req8, gnt8, rd_valid8, dec_valid8;
  logic [AW-1:0] pf_addr8;
  logic [7:0] rd_data8, dec_byte8;
  logic [2:0] dec_count8;

  int nchk = 0;
  int nfail = 0;

  pfq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_addr_i(flush_addr),
    .eu_req_i(eu_req), .pf_req_o(pf_req), .pf_addr_o(pf_addr), .pf_grant_i(gnt),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .dec_rd_i(dec_rd),
    .dec_byte_o(dec_byte), .dec_valid_o(dec_valid), .dec_count_o(dec_count)
  );
  pfq_mem_model #(.BUS_BYTES(2), .ADDR_W(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .req(pf_req), .addr(pf_addr), .gnt_en(gnt_en),
    .gnt(gnt), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pfq_ctrl #(.BUS_BYTES(1)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush8), .flush_addr_i(flush_addr8),
    .eu_req_i(1'b0), .pf_req_o(pf_req8), .pf_addr_o(pf_addr8), .pf_grant_i(gnt8),
    .rd_valid_i(rd_valid8), .rd_data_i(rd_data8), .dec_rd_i(dec_rd8),
    .dec_byte_o(dec_byte8), .dec_valid_o(dec_valid8), .dec_count_o(dec_count8)
  );
  pfq_mem_model #(.BUS_BYTES(1), .ADDR_W(AW)) u_mem8 (
    .clk(clk), .rst_n(rst_n), .req(pf_req8), .addr(pf_addr8), .gnt_en(1'b1),
    .gnt(gnt8), .rd_valid(rd_valid8), .rd_data(rd_data8)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] x);
    return x[7:0] + 8'(x[15:8] * 3) + 8'h11;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_flush(input logic [AW-1:0] a);
    flush = 1'b1; flush_addr = a;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // stimulus table: start address, bytes to read, idle cycles between pops, data-access load
  localparam int NV = 4;
  localparam logic [AW-1:0] V_ADDR [NV] = '{20'h00100, 20'h00201, 20'h0FFFE, 20'h00040};
  localparam int V_LEN [NV] = '{10, 9, 12, 8};
  localparam int V_GAP [NV] = '{0, 2, 1, 3};
  localparam int V_EU  [NV] = '{0, 1, 2, 0};

  task automatic run_stream(input logic [AW-1:0] a, input int len, input int gap, input int eu);
    logic [AW-1:0] exp_a;
    int got, wait_c, cyc;
    exp_a = a; got = 0; wait_c = 0; cyc = 0;
    do_flush(a);
    while (got < len && cyc < 2000) begin
      eu_req = ((cyc % 4) < eu);
      chk(dec_count <= 3'd6, "R8", dec_count, 6);
      if (wait_c == 0 && dec_valid) begin
        chk(dec_byte == mem_byte(exp_a), "R1", dec_byte, mem_byte(exp_a));
        dec_rd = 1'b1; exp_a = exp_a + 1; got++; wait_c = gap;
      end else begin
        dec_rd = 1'b0;
        if (wait_c > 0) wait_c--;
      end
      @(negedge clk);
      cyc++;
    end
    dec_rd = 1'b0; eu_req = 1'b0;
    chk(got == len, "R1", got, len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; eu_req = 1'b0; gnt_en = 1'b0; dec_rd = 1'b0;
    flush_addr = '0; flush8 = 1'b0; flush_addr8 = '0; dec_rd8 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(dec_count == 0, "R9", dec_count, 0);
    chk(!dec_valid, "R9", dec_valid, 0);
    chk(pf_addr == 20'hFFFF0, "R9", pf_addr, 20'hFFFF0);
    chk(pf_req, "R9", pf_req, 1);

    // R2: empty queue ignores pops
    dec_rd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dec_count == 0 && !dec_valid, "R2", dec_count, 0);
    end
    dec_rd = 1'b0;

    // R3: pending data access blocks prefetch
    eu_req = 1'b1; gnt_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!pf_req, "R3", pf_req, 0);
    end
    chk(dec_count == 0, "R3", dec_count, 0);
    eu_req = 1'b0;

    for (int v = 0; v < NV; v++) run_stream(V_ADDR[v], V_LEN[v], V_GAP[v], V_EU[v]);

    // R4: fill, stop at full and at one free slot, resume at two
    do_flush(20'h00300);
    repeat (40) @(negedge clk);
    chk(dec_count == 6, "R4", dec_count, 6);
    chk(!pf_req, "R4", pf_req, 0);
    dec_rd = 1'b1; @(negedge clk); dec_rd = 1'b0;
    chk(dec_count == 5, "R8", dec_count, 5);
    chk(!pf_req, "R4", pf_req, 0);
    dec_rd = 1'b1; @(negedge clk); dec_rd = 1'b0;
    chk(dec_count == 4, "R8", dec_count, 4);
    chk(pf_req, "R4", pf_req, 1);
    chk(dec_byte == mem_byte(20'h00302), "R1", dec_byte, mem_byte(20'h00302));

    // R7: odd fetch brings one byte
    do_flush(20'h00401);
    for (int i = 0; i < 20 && !dec_valid; i++) @(negedge clk);
    chk(dec_count == 1, "R7", dec_count, 1);
    chk(dec_byte == mem_byte(20'h00401), "R7", dec_byte, mem_byte(20'h00401));
    run_stream(20'h00403, 5, 0, 0);

    // R5 and R6: flush while a prefetch is in flight
    do_flush(20'h00500);
    for (int i = 0; i < 20 && !gnt; i++) @(negedge clk);
    @(negedge clk);
    do_flush(20'h00600);
    chk(dec_count == 0, "R5", dec_count, 0);
    chk(pf_addr == 20'h00600, "R5", pf_addr, 20'h00600);
    for (int i = 0; i < 20 && !dec_valid; i++) @(negedge clk);
    chk(dec_byte == mem_byte(20'h00600), "R6", dec_byte, mem_byte(20'h00600));

    // R6: flush coinciding with the data return
    do_flush(20'h00700);
    for (int i = 0; i < 20 && !rd_valid; i++) @(negedge clk);
    chk(rd_valid, "R6", rd_valid, 1);
    do_flush(20'h00800);
    chk(dec_count == 0, "R6", dec_count, 0);
    for (int i = 0; i < 20 && !dec_valid; i++) @(negedge clk);
    chk(dec_byte == mem_byte(20'h00800), "R6", dec_byte, mem_byte(20'h00800));

    // R10: byte-wide variant fills to 4 and drains in order
    flush8 = 1'b1; flush_addr8 = 20'h00900;
    @(negedge clk);
    flush8 = 1'b0;
    repeat (40) @(negedge clk);
    chk(dec_count8 == 4, "R10", dec_count8, 4);
    chk(!pf_req8, "R10", pf_req8, 0);
    for (int i = 0; i < 4; i++) begin
      chk(dec_byte8 == mem_byte(20'h00900 + AW'(i)), "R10", dec_byte8, mem_byte(20'h00900 + AW'(i)));
      dec_rd8 = 1'b1; @(negedge clk); dec_rd8 = 1'b0;
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule